// File: doc/BRIEF.md
# Multi-Segment Output Pixel Buffer

This block is the last line-based stage before a display link. It takes in one line of pixels of a configured active width and stores it in a line buffer. It then plays the line back as one, two or four segments, in order. Neighbouring segments share a configurable band of overlap pixels, which suits panels that are driven as several side-by-side slices. During playback each stored pixel can be sent out up to sixteen times in a row. The block does this for modes that send a pixel more than once per clock.

Input and output are valid/ready streams. Every output beat carries the index of the segment it belongs to. A start-of-line flag marks the first beat of each line. While a line is being played back, the input is held off, and this includes the time spent repeating a pixel. One segmentation mode covers a panel split into a left and a right half. In that mode each line holds half the panel as two segments. Even lines are tagged as segments 0 and 1, and odd lines as segments 2 and 3. A configuration that cannot be split cleanly raises an error flag, and no pixels are accepted while the flag is high.

Top module: `mso_pixel_buffer`

## Requirements
- R1: While not playing back and the configuration is valid, `in_ready` is high. Exactly `cfg_width` pixels are accepted per line. `in_ready` then stays low until the last beat of that line has been accepted on the output.
- R2: Each output pixel is sent `cfg_repeat + 1` times on consecutive accepted beats, with `cfg_repeat` in 0..15. A value of 0 sends each pixel once.
- R3: `cfg_seg_mode` sets the number of segments per line. 0 gives one segment, 1 gives two and 2 gives four. 3 is the left/right split: two segments per line, tagged 0 and 1 on even lines and 2 and 3 on odd lines. Line parity starts even after reset and toggles only on lines played back in mode 3.
- R4: With N segments per line, the segment width is S = `cfg_width`/N and the overlap is V = `cfg_overlap` + 1 (1..8). Local segment k sends pixel positions k*S - V through (k+1)*S - 1 + V in ascending order. No overlap is added before segment 0 or after the last segment.
- R5: `out_seg` carries the segment index of every output beat. `out_sol` is high on the first beat of a line only.
- R6: `cfg_err` is high in any of these cases: `cfg_width` is 0; `cfg_width` exceeds MAX_WIDTH; `cfg_width` is not a multiple of N; or N > 1 and V > S. While `cfg_err` is high and no line is in flight, `in_ready` is low and nothing is accepted.
- R7: While `out_valid` is high and `out_ready` is low, `out_data`, `out_seg` and `out_sol` hold their values.
- R8: Playback starts in the cycle after the last pixel of a line is accepted. In that cycle `out_valid` and `out_sol` are high.
- R9: After reset, `out_valid` is low and `in_ready` is high for a valid configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | $clog2(MAX_WIDTH+1) | Active pixels per line |
| cfg_seg_mode | input | 2 | 0: one, 1: two, 2: four segments, 3: left/right split |
| cfg_overlap | input | 3 | Overlap pixels minus one |
| cfg_repeat | input | 4 | Extra sends per pixel |
| cfg_err | output | 1 | Configuration cannot be split |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | PIX_W | Input pixel |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_data | output | PIX_W | Output pixel |
| out_sol | output | 1 | First beat of a line |
| out_seg | output | 2 | Segment index of the beat |

## Verification
Lines are sent with a distinct value at every position. A dropped, doubled or misplaced pixel therefore shows up as a value mismatch against a model of the segment spans. A single-segment, no-repeat line checks plain storage and playback. The two- and four-segment lines use overlaps of 1, 2 and the full segment width, which separates correct boundary handling from off-by-one spans. Repeat counts of 1, 3 and 15 under random output stalls separate repetition from stall holding. Two back-to-back left/right-split lines show the segment tags alternating between halves. Invalid configurations with the input asserted show that no pixel slips into the buffer before the next valid line.

// File: rtl/mso_pixel_buffer.sv
module mso_pixel_buffer #(
  parameter int PIX_W     = 24,
  parameter int MAX_WIDTH = 64,
  localparam int AW = $clog2(MAX_WIDTH),
  localparam int WW = $clog2(MAX_WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WW-1:0]    cfg_width,
  input  logic [1:0]       cfg_seg_mode,
  input  logic [2:0]       cfg_overlap,
  input  logic [3:0]       cfg_repeat,
  output logic             cfg_err,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sol,
  output logic [1:0]       out_seg
);
  localparam int XW = WW + 2;

  logic [PIX_W-1:0] line_mem [MAX_WIDTH];
  logic             emitting, odd_line;
  logic [WW-1:0]    wr_idx;
  logic [XW-1:0]    rd_idx;
  logic [1:0]       seg;
  logic [3:0]       rep_cnt;

  logic [1:0]    seg_sh, last_seg;
  logic [WW-1:0] seg_w;
  logic [3:0]    ov;
  logic [XW-1:0] seg_base, seg_end, next_start;
  logic          last_in;

  assign seg_sh   = (cfg_seg_mode == 2'd0) ? 2'd0 : (cfg_seg_mode == 2'd2) ? 2'd2 : 2'd1;
  assign last_seg = (seg_sh == 2'd0) ? 2'd0 : (seg_sh == 2'd1) ? 2'd1 : 2'd3;
  assign seg_w    = cfg_width >> seg_sh;
  assign ov       = {1'b0, cfg_overlap} + 4'd1;

  assign cfg_err = (cfg_width == '0) || (cfg_width > WW'(MAX_WIDTH)) ||
                   ((cfg_width & WW'(last_seg)) != '0) ||
                   ((last_seg != 2'd0) && (WW'(ov) > seg_w));

  assign seg_base   = XW'(seg) * XW'(seg_w);
  assign seg_end    = seg_base + XW'(seg_w) - XW'(1) + ((seg != last_seg) ? XW'(ov) : '0);
  assign next_start = seg_base + XW'(seg_w) - XW'(ov);

  assign in_ready  = !emitting && !cfg_err;
  assign last_in   = in_valid && in_ready && (wr_idx == cfg_width - WW'(1));
  assign out_valid = emitting;
  assign out_data  = line_mem[rd_idx[AW-1:0]];
  assign out_sol   = emitting && (seg == 2'd0) && (rd_idx == '0) && (rep_cnt == 4'd0);
  assign out_seg   = seg + (((cfg_seg_mode == 2'd3) && odd_line) ? 2'd2 : 2'd0);

  always_ff @(posedge clk)
    if (in_valid && in_ready) line_mem[wr_idx[AW-1:0]] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emitting <= 1'b0;
      odd_line <= 1'b0;
      wr_idx   <= '0;
      rd_idx   <= '0;
      seg      <= '0;
      rep_cnt  <= '0;
    end else if (!emitting) begin
      if (last_in) begin
        emitting <= 1'b1;
        wr_idx   <= '0;
        rd_idx   <= '0;
        seg      <= '0;
        rep_cnt  <= '0;
      end else if (in_valid && in_ready) begin
        wr_idx <= wr_idx + WW'(1);
      end
    end else if (out_ready) begin
      if (rep_cnt != cfg_repeat) begin
        rep_cnt <= rep_cnt + 4'd1;
      end else begin
        rep_cnt <= '0;
        if (rd_idx == seg_end) begin
          if (seg == last_seg) begin
            emitting <= 1'b0;
            if (cfg_seg_mode == 2'd3) odd_line <= !odd_line;
          end else begin
            seg    <= seg + 2'd1;
            rd_idx <= next_start;
          end
        end else begin
          rd_idx <= rd_idx + XW'(1);
        end
      end
    end
  end

  // R2: a pixel still being repeated stays on the output
  assert_repeat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && rep_cnt != cfg_repeat) |=>
      (out_valid && $stable(out_data) && $stable(out_seg)));

  // R7: a stalled beat is held unchanged
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_seg) && $stable(out_sol)));

  // R8: playback opens with the line-start beat right after the last input
  assert_emit_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_in |=> (out_valid && out_sol && !in_ready));

  // R5: a line always starts on the first segment of its half
  assert_sol_seg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sol |-> (out_seg == 2'd0 || out_seg == 2'd2));
endmodule

// File: tb/mso_pixel_buffer_test.sv
`timescale 1ns/1ps
module mso_pixel_buffer_test;
  localparam int PW = 24;
  localparam int MW = 64;
  localparam int WW = $clog2(MW + 1);

  typedef struct packed {
    logic [PW-1:0] d;
    logic [1:0]    s;
    logic          sol;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WW-1:0] cfg_width = WW'(8);
  logic [1:0] cfg_seg_mode = 2'd0;
  logic [2:0] cfg_overlap = 3'd0;
  logic [3:0] cfg_repeat = 4'd0;
  logic cfg_err, in_ready, out_valid, out_sol;
  logic in_valid = 1'b0;
  logic [PW-1:0] in_data = '0;
  logic out_ready = 1'b1;
  logic [PW-1:0] out_data;
  logic [1:0] out_seg;

  beat_t exp_q[$];
  int checks = 0;
  int fails = 0;
  bit odd_exp = 1'b0;
  bit stall_en = 1'b0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  mso_pixel_buffer #(.PIX_W(PW), .MAX_WIDTH(MW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_seg_mode(cfg_seg_mode),
    .cfg_overlap(cfg_overlap), .cfg_repeat(cfg_repeat), .cfg_err(cfg_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sol(out_sol), .out_seg(out_seg));

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  beat_t prev;
  bit prev_stall = 1'b0;
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (prev_stall)
        check({out_data, out_seg, out_sol} == prev, "R7", "stalled beat held",
              {out_data, out_seg, out_sol}, prev);
      if (out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected output beat", out_data, 0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          check(out_data == e.d, "R2/R4", "pixel value", out_data, e.d);
          check(out_seg == e.s, "R3", "segment index", out_seg, e.s);
          check(out_sol == e.sol, "R5", "line start flag", out_sol, e.sol);
        end
      end
      prev = {out_data, out_seg, out_sol};
      prev_stall = !out_ready;
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic send_line(int w, int tag);
    int n, sw, v, base;
    n = (cfg_seg_mode == 2'd0) ? 1 : (cfg_seg_mode == 2'd2) ? 4 : 2;
    sw = w / n;
    v = cfg_overlap + 1;
    base = (cfg_seg_mode == 2'd3 && odd_exp) ? 2 : 0;
    if (cfg_seg_mode == 2'd3) odd_exp = !odd_exp;
    for (int s = 0; s < n; s++) begin
      int st, en;
      st = s * sw - ((s > 0) ? v : 0);
      en = (s + 1) * sw - 1 + ((s < n - 1) ? v : 0);
      for (int p = st; p <= en; p++)
        for (int r = 0; r <= int'(cfg_repeat); r++) begin
          beat_t b;
          b.d = PW'((tag << 8) | p);
          b.s = 2'(s + base);
          b.sol = (s == 0 && p == st && r == 0);
          exp_q.push_back(b);
        end
    end
    for (int p = 0; p < w; p++) begin
      in_valid = 1'b1;
      in_data = PW'((tag << 8) | p);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && out_sol, "R8", "playback starts after last pixel", {out_valid, out_sol}, 3);
    check(!in_ready, "R1", "input held off during playback", in_ready, 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(int w, int mode, int ovf, int rep);
    cfg_width = WW'(w);
    cfg_seg_mode = 2'(mode);
    cfg_overlap = 3'(ovf);
    cfg_repeat = 4'(rep);
  endtask

  task automatic expect_err(int w, int mode, int ovf, string what);
    set_cfg(w, mode, ovf, 0);
    in_valid = 1'b1;
    in_data = 24'hDEAD00;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(cfg_err == 1'b1, "R6", what, cfg_err, 1);
      check(!in_ready && !out_valid, "R6", "nothing accepted on error",
            {in_ready, out_valid}, 0);
      @(posedge clk);
      #1;
      in_data = in_data + 1;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R9", "out_valid after reset", out_valid, 0);
    check(in_ready && !cfg_err, "R9", "in_ready after reset", in_ready, 1);
    @(posedge clk);
    #1;

    set_cfg(8, 0, 0, 0);   send_line(8, 1);  drain();
    stall_en = 1'b1;
    set_cfg(8, 0, 0, 3);   send_line(8, 2);  drain();
    stall_en = 1'b0;
    set_cfg(16, 1, 1, 0);  send_line(16, 3); drain();
    stall_en = 1'b1;
    set_cfg(16, 2, 0, 1);  send_line(16, 4); drain();
    set_cfg(32, 2, 7, 0);  send_line(32, 5); drain();
    set_cfg(12, 3, 2, 0);  send_line(12, 6); drain();
    send_line(12, 7); drain();
    set_cfg(4, 0, 0, 15);  send_line(4, 8);  drain();

    expect_err(6, 2, 0, "width not a multiple of four");
    expect_err(0, 0, 0, "zero width");
    expect_err(8, 2, 2, "overlap wider than segment");
    expect_err(MW + 1, 0, 0, "width over maximum");

    set_cfg(MW, 1, 7, 0);  send_line(MW, 9); drain();
    set_cfg(12, 3, 0, 2);  send_line(12, 10); drain();

    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule